// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This controller lets logic running on a system clock read and write an external static RAM that has no clock of its own. The host offers one request at a time over a valid/ready handshake, carrying a direction bit, an address and, for writes, one data byte. The controller then sequences the memory's three active-low strobes (chip select, output enable, write strobe), holds the address and write data steady, and controls when its own data drivers are switched on.

Every strobe phase lasts a whole number of clock cycles. These counts come from the memory's timing limits, given in picoseconds, and the clock period. Each count is the limit divided by the period, rounded up, and never less than one cycle. A read holds chip select and output enable low. The byte is sampled on the clock edge that ends the strobe and is handed back with a one-cycle response pulse. A write keeps output enable high for its whole length, so the shorter write-strobe minimum applies. A write has a setup phase and then a write-strobe phase. The controller's data drivers come on only once the memory has had time to release the bus after the write strobe falls, and they go off on the same edge that raises the strobe.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: A read (req_write=0) holds mem_ce_n=0 and mem_oe_n=0, with mem_we_n=1, for RD_CYC consecutive cycles beginning the cycle after acceptance. RD_CYC is the larger of the read-cycle and address-access counts (2 at defaults).
- R3: Read data is sampled from mem_dq_in on the edge that ends the read strobe. It is presented on rsp_rdata with rsp_valid high for exactly one cycle, the cycle after the strobes rise.
- R4: A write (req_write=1) holds mem_ce_n=0 for SU_CYC+PW_CYC cycles. mem_we_n is 1 for the first SU_CYC of these cycles and 0 for the last PW_CYC. mem_oe_n stays 1 throughout. Defaults: SU_CYC=1, PW_CYC=2.
- R5: mem_dq_oe rises only after mem_we_n has been 0 for DLY_CYC cycles (1 at defaults). It falls on the same edge that raises mem_we_n, and it is never 1 while mem_oe_n is 0.
- R6: req_ready is 0 from the edge after acceptance until the access ends. A request offered while req_ready is 0 is ignored and writes nothing.
- R7: mem_addr and mem_dq_out stay equal to the accepted request for the whole time mem_ce_n is 0, whatever the request inputs do meanwhile.
- R8: Each cycle count is ceil(t_ps / CLK_PS) with a minimum of one. PW_CYC is at least DLY_CYC plus the data-setup count. SU_CYC+PW_CYC covers both the write-cycle count and the address-to-write-end count.
- R9: A write produces no rsp_valid pulse.
- R10: mem_we_n and mem_oe_n are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the controller's data drivers |
| mem_dq_in | input | DW | Byte seen on the memory data bus |

## Verification
The hardest case to reach from the ports is the moment a read is sampled. A controller that samples one cycle early can still return correct data from a memory model that answers at once. The bench's memory model therefore returns a filler byte during the first cycle of each read strobe and returns the stored byte only after that. Drive contention is checked on every cycle against the strobes. A request is also offered while the controller is busy, and a later read of its address shows that the request had no effect.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_READ,
    SQ_WSETUP,
    SQ_WPULSE
  } seq_state_e;

  // whole cycles covering a picosecond limit, never below one
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // strobe length: long enough for the pulse minimum and for release plus data setup
  function automatic int pulse_cyc(input int pwe_c, input int dly_c, input int sd_c);
    return imax(pwe_c, dly_c + sd_c);
  endfunction

  // setup phase: fills the write cycle and address-to-end windows
  function automatic int setup_cyc(input int aw_c, input int wc_c, input int pw_c);
    return imax(1, imax(aw_c - pw_c, wc_c - pw_c));
  endfunction

  function automatic int cnt_width(input int maxc);
    return (maxc > 1) ? $clog2(maxc) : 1;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 2,
  parameter int SU_CYC  = 1,
  parameter int PW_CYC  = 2,
  parameter int DLY_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic busy,
  output logic cap,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic drv_en
);

  localparam int MAXC = imax(RD_CYC, imax(SU_CYC, PW_CYC));
  localparam int CW   = cnt_width(MAXC);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            drv_d;
  int              elapsed;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap     = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = start_wr ? SQ_WSETUP : SQ_READ;
          cnt_d   = start_wr ? CW'(SU_CYC - 1) : CW'(RD_CYC - 1);
        end
      end
      SQ_READ: begin
        if (cnt_q == '0) begin
          state_d = SQ_IDLE;
          cap     = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_WSETUP: begin
        if (cnt_q == '0) begin
          state_d = SQ_WPULSE;
          cnt_d   = CW'(PW_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_WPULSE: begin
        if (cnt_q == '0) state_d = SQ_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // cycles already spent in the write strobe once the next state is entered
  always_comb begin
    elapsed = (PW_CYC - 1) - int'(cnt_d);
    drv_d   = (state_d == SQ_WPULSE) && (elapsed >= DLY_CYC);
  end

  // strobes are flops so the memory never sees decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      drv_en  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ce_n    <= (state_d == SQ_IDLE);
      oe_n    <= (state_d != SQ_READ);
      we_n    <= (state_d != SQ_WPULSE);
      drv_en  <= drv_d;
    end
  end

  assign busy = (state_q != SQ_IDLE);

endmodule

// File: rtl/sram_data_hold.sv
module sram_data_hold #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rsp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (load) begin
        addr_q  <= in_addr;
        wdata_q <= in_wdata;
      end
      if (cap) rdata_q <= dq_in;
      rsp_q <= cap;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_PS    = 8000,
  parameter int T_RC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_WC_PS   = 10000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SD_PS   = 6000,
  parameter int T_AW_PS   = 8000,
  parameter int T_WHZ_PS  = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int RD_CYC  = imax(cyc_of(T_RC_PS, CLK_PS), cyc_of(T_AA_PS, CLK_PS));
  localparam int DLY_CYC = cyc_of(T_WHZ_PS, CLK_PS);
  localparam int PW_CYC  = pulse_cyc(cyc_of(T_PWE_PS, CLK_PS), DLY_CYC,
                                     cyc_of(T_SD_PS, CLK_PS));
  localparam int SU_CYC  = setup_cyc(cyc_of(T_AW_PS, CLK_PS),
                                     cyc_of(T_WC_PS, CLK_PS), PW_CYC);

  // named events for the checker
  logic accept;
  logic busy;
  logic cap_evt;

  assign accept    = req_valid && !busy;
  assign req_ready = !busy;

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .SU_CYC (SU_CYC),
    .PW_CYC (PW_CYC),
    .DLY_CYC(DLY_CYC)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .start_wr(req_write),
    .busy    (busy),
    .cap     (cap_evt),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .drv_en  (mem_dq_oe)
  );

  sram_data_hold #(
    .AW(AW),
    .DW(DW)
  ) hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .in_addr (req_addr),
    .in_wdata(req_wdata),
    .cap     (cap_evt),
    .dq_in   (mem_dq_in),
    .addr_q  (mem_addr),
    .wdata_q (mem_dq_out),
    .rdata_q (rsp_rdata),
    .rsp_q   (rsp_valid)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic          accept,
  input logic          cap_evt
);

  a_r5_no_drive_while_oe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r5_drive_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  a_r5_release_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

  a_r10_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r6_idle_means_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r3_capture_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (rsp_valid && mem_oe_n));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe),
  .accept    (accept),
  .cap_evt   (cap_evt)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

  // expected phase lengths restated from the ns limits and an 8 ns clock (R8)
  localparam real PER  = 8.0;
  localparam int  E_RD  = (int'($ceil(10.0 / PER)) > 1) ? int'($ceil(10.0 / PER)) : 1;
  localparam int  E_DLY = (int'($ceil(5.0 / PER)) > 1) ? int'($ceil(5.0 / PER)) : 1;
  localparam int  E_SDC = (int'($ceil(6.0 / PER)) > 1) ? int'($ceil(6.0 / PER)) : 1;
  localparam int  E_PW  = (int'($ceil(8.0 / PER)) > E_DLY + E_SDC) ? int'($ceil(8.0 / PER))
                                                                   : E_DLY + E_SDC;
  localparam int  E_SU  = (int'($ceil(10.0 / PER)) - E_PW > 1) ? int'($ceil(10.0 / PER)) - E_PW : 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int errors = 0;
  int checks = 0;
  int clash  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory model: stored byte appears only after one full strobe cycle
  logic [7:0] store [int];
  int rd_age = 0;
  logic reading;
  assign reading = !mem_ce_n && !mem_oe_n && mem_we_n;

  function automatic logic [7:0] peek(input int a);
    return store.exists(a) ? store[a] : 8'h00;
  endfunction

  assign mem_dq_in = (reading && rd_age >= 1) ? peek(int'(mem_addr)) : 8'hEE;

  always @(posedge clk) rd_age <= reading ? rd_age + 1 : 0;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) store[int'(mem_addr)] = mem_dq_out;
    if (mem_dq_oe && !mem_oe_n) clash++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic [16:0] a, input logic [7:0] d,
                        input logic [7:0] exp, input bit poke);
    int ce_c = 0, oe_c = 0, we_c = 0, su_c = 0, drv_c = 0, bad_drv = 0;
    int first_drv = -1, last_drv_we = -1, rdy_lo = 0, rsp_c = 0, rsp_at = -1, moves = 0;
    logic [7:0] got = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (!mem_ce_n) ce_c++;
      if (!mem_oe_n) oe_c++;
      if (!mem_we_n) we_c++;
      else if (!mem_ce_n && we_c == 0) su_c++;
      if (mem_dq_oe) begin
        drv_c++;
        if (mem_we_n) bad_drv++;
        if (first_drv < 0) first_drv = we_c - 1;
        if (!mem_we_n) last_drv_we = we_c;
      end
      if (!req_ready) rdy_lo++;
      if (rsp_valid) begin rsp_c++; rsp_at = n; got = rsp_rdata; end
      if (!mem_ce_n && (mem_addr != a || (wr && mem_dq_out != d))) moves++;
      if (n == 1) begin
        req_addr = ~a; req_wdata = ~d;
        req_valid = poke; req_write = 1'b1;
        if (poke) begin req_addr = 17'h00050; req_wdata = 8'h22; end
      end
      if (n == 2) req_valid = 1'b0;
    end
    chk(moves == 0, "R7 address/data held", moves, 0);
    chk(oe_c == (wr ? 0 : E_RD), "R2/R4 oe low cycles", oe_c, wr ? 0 : E_RD);
    if (wr) begin
      chk(ce_c == E_SU + E_PW, "R4/R8 ce low cycles (write)", ce_c, E_SU + E_PW);
      chk(we_c == E_PW, "R4/R8 we low cycles", we_c, E_PW);
      chk(su_c == E_SU, "R4 setup cycles", su_c, E_SU);
      chk(drv_c == E_PW - E_DLY && first_drv == E_DLY, "R5 driver start", first_drv, E_DLY);
      chk(bad_drv == 0 && last_drv_we == E_PW, "R5 driver release", last_drv_we, E_PW);
      chk(rsp_c == 0, "R9 no response on write", rsp_c, 0);
      chk(rdy_lo == E_SU + E_PW, "R6 ready low (write)", rdy_lo, E_SU + E_PW);
    end else begin
      chk(ce_c == E_RD && we_c == 0, "R2/R8 ce low cycles (read)", ce_c, E_RD);
      chk(rsp_c == 1 && rsp_at == E_RD + 1, "R3 response pulse timing", rsp_at, E_RD + 1);
      chk(got == exp, "R3 read data", int'(got), int'(exp));
      chk(rdy_lo == E_RD, "R6 ready low (read)", rdy_lo, E_RD);
    end
  endtask

  // {write, address, write byte, expected read byte}
  localparam logic [33:0] OPS [9] = '{
    {1'b1, 17'h00010, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
    {1'b1, 17'h00000, 8'hFF, 8'h00},
    {1'b0, 17'h00010, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
    {1'b0, 17'h00000, 8'h00, 8'hFF},
    {1'b1, 17'h00010, 8'h5A, 8'h00},
    {1'b0, 17'h00010, 8'h00, 8'h5A},
    {1'b0, 17'h00123, 8'h00, 8'h00}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held and after release
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_dq_oe && req_ready && !rsp_valid, "R1 idle after reset",
        int'({mem_dq_oe, req_ready, rsp_valid}), 2);

    for (int i = 0; i < 9; i++)
      run_op(OPS[i][33], OPS[i][32:16], OPS[i][15:8], OPS[i][7:0], 1'b0);

    // R6: request offered while busy with a write must be ignored
    run_op(1'b1, 17'h00040, 8'h11, 8'h00, 1'b1);
    run_op(1'b0, 17'h00050, 8'h00, 8'h00, 1'b0);
    run_op(1'b0, 17'h00040, 8'h00, 8'h11, 1'b0);

    repeat (2) @(negedge clk);
    chk(clash == 0, "R5/R10 no bus contention", clash, 0);
    chk(req_ready && mem_ce_n, "R6 idle at end", int'({req_ready, mem_ce_n}), 3);
    finish_run();
  end

endmodule